// File: doc/BRIEF.md
# Dual-Mode Converter Bus Interface

This block is the device-side bus logic of an 8-bit parallel-output converter. A host reaches it through three active-low strobes (chip select, read and write), an active-low end-of-conversion flag and an 8-bit data bus. The data bus is brought out as a value and an output enable, so the pad ring can build the tri-state driver. A second output enables an open-drain pull-down on the shared write/ready pin. All inputs are taken to be already synchronous to `clk`. Edges are found by comparing each input with its value at the previous clock edge.

A mode input picks one of two handshakes. In read mode (`mode_i` = 0), a falling read strobe starts a conversion. The ready pin is pulled low while the conversion runs, and the result goes onto the bus while read stays low. In write-read mode (`mode_i` = 1), a falling write strobe starts acquisition. The rising write strobe captures the upper nibble and starts the lower nibble. A read strobe that arrives before the end flag asks the conversion core to finish early. With chip select and read tied low, write pulses alone run the converter, and each result stays on the bus until the next write pulse rises.

The block drives three single-cycle requests to the conversion core: start, lower-nibble start and early finish. It takes back the two nibbles and a done strobe. A write strobe that comes too soon after the previous end of conversion is refused and flagged.

Top module: `adc_bus_if`

## Requirements
- R1: With `mode_i`=0 a qualified read falling edge starts a conversion and a write falling edge starts nothing; with `mode_i`=1 a write falling edge starts one and a read falling edge while idle starts nothing.
- R2: While `cs_n_i` is high, neither a read nor a write falling edge starts a conversion or raises any request.
- R3: In read mode, a read falling edge with `cs_n_i` low gives a one-cycle `conv_start_o` pulse in the next cycle. The `conv_done_i` edge latches `{conv_hi_i, conv_lo_i}` as the result.
- R4: In read mode, `rdy_pull_o` goes high the cycle after `cs_n_i` falls. It drops the cycle after `conv_done_i` is taken, or after `cs_n_i` rises.
- R5: `int_n_o` goes low in the cycle after a conversion's `conv_done_i` is taken. It returns high the cycle after a rising edge of `cs_n_i` or `rd_n_i`, or when a new conversion starts.
- R6: In write-read mode, the cycle after write falls `conv_start_o` pulses. The cycle after write rises `conv_lower_o` pulses, and `data_o[7:4]` holds the `conv_hi_i` value sampled at that edge. `data_o[3:0]` takes `conv_lo_i` at done.
- R7: In write-read mode, a read falling edge with `cs_n_i` low between the write rising edge and done gives a one-cycle `conv_finish_o` pulse. `int_n_o` stays high until done is taken.
- R8: With `cs_n_i` and `rd_n_i` held low in write-read mode, the previous result stays driven and unchanged through the next write falling edge. It leaves the bus when that pulse's write rising edge is sampled.
- R9: `data_oe_o` is high only while a complete result is held and both `cs_n_i` and `rd_n_i` are low. While it stays high, `data_o` does not change.
- R10: In write-read mode, a write falling edge sampled within the `ACQ_CYCLES` clock edges after the edge that lowered `int_n_o` starts nothing and pulses `wr_viol_o` for one cycle. One edge later, the same edge is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_i | input | 1 | Handshake select: 0 read mode, 1 write-read mode |
| cs_n_i | input | 1 | Chip select, active low |
| rd_n_i | input | 1 | Read strobe, active low |
| wr_n_i | input | 1 | Write strobe, active low (input side of the write/ready pin) |
| int_n_o | output | 1 | End-of-conversion flag, active low |
| rdy_pull_o | output | 1 | Pull-down enable for the open-drain ready output |
| data_o | output | 8 | Result value for the bus driver |
| data_oe_o | output | 1 | Bus driver enable; bus high-impedance when low |
| conv_start_o | output | 1 | One-cycle request to begin a conversion |
| conv_lower_o | output | 1 | One-cycle request to begin the lower nibble |
| conv_finish_o | output | 1 | One-cycle request to complete the conversion early |
| conv_hi_i | input | 4 | Upper nibble from the conversion core |
| conv_lo_i | input | 4 | Lower nibble from the conversion core |
| conv_done_i | input | 1 | Conversion core done strobe |
| wr_viol_o | output | 1 | One-cycle flag for a refused early write strobe |

## Verification
The assertions take for granted that the conversion core raises `conv_done_i` only while a conversion is open. They also take for granted that the strobes change no more than once per clock, so each change is seen as an edge. The stimulus holds done until the bench has started a conversion and, in write-read mode, seen the write strobe rise. It changes each strobe only on the falling clock edge. Random transactions are spaced by an idle gap longer than the acquisition interval, and the refusal window is reached only by the directed cases.

// File: rtl/adc_bus_pkg.sv
package adc_bus_pkg;

    localparam int unsigned NIB_W  = 4;
    localparam int unsigned DATA_W = 2 * NIB_W;

    localparam int unsigned PIN_CNT = 3;
    localparam int unsigned PIN_CS  = 0;
    localparam int unsigned PIN_RD  = 1;
    localparam int unsigned PIN_WR  = 2;

    typedef enum logic [1:0] {
        ST_IDLE     = 2'd0,
        ST_RD_BUSY  = 2'd1,
        ST_WR_TRACK = 2'd2,
        ST_WR_LOWER = 2'd3
    } ctl_state_e;

    typedef struct packed {
        ctl_state_e        st;
        logic [DATA_W-1:0] data;
        logic              valid;
        logic              int_n;
        logic              rdy_pull;
        logic              start;
        logic              lower;
        logic              finish;
        logic              viol;
    } ctl_regs_t;

    localparam ctl_regs_t CTL_RESET = '{
        st:       ST_IDLE,
        data:     '0,
        valid:    1'b0,
        int_n:    1'b1,
        rdy_pull: 1'b0,
        start:    1'b0,
        lower:    1'b0,
        finish:   1'b0,
        viol:     1'b0
    };

endpackage

// File: rtl/adc_bus_edges.sv
module adc_bus_edges #(
    parameter int unsigned N = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] pins_i,
    output logic [N-1:0] fall_o,
    output logic [N-1:0] rise_o
);

    logic [N-1:0] prev_q;
    logic [N-1:0] prev_d;

    for (genvar g = 0; g < N; g++) begin : g_pin
        always_comb begin
            prev_d[g] = pins_i[g];
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                prev_q[g] <= 1'b1;
            end else begin
                prev_q[g] <= prev_d[g];
            end
        end

        assign fall_o[g] = prev_q[g] & ~pins_i[g];
        assign rise_o[g] = ~prev_q[g] & pins_i[g];
    end

endmodule

// File: rtl/adc_bus_acq_timer.sv
module adc_bus_acq_timer #(
    parameter int unsigned ACQ_CYCLES = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load_i,
    output logic busy_o
);

    localparam int unsigned CW = (ACQ_CYCLES < 1) ? 1 : $clog2(ACQ_CYCLES + 1);
    localparam logic [CW-1:0] LOAD_VAL = CW'(ACQ_CYCLES);

    logic [CW-1:0] cnt_q;
    logic [CW-1:0] cnt_d;

    always_comb begin
        cnt_d = cnt_q;
        if (load_i) begin
            cnt_d = LOAD_VAL;
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - CW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign busy_o = (cnt_q != '0);

endmodule

// File: rtl/adc_bus_ctrl.sv
module adc_bus_ctrl
    import adc_bus_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode_i,
    input  logic              cs_n_i,
    input  logic              rd_n_i,
    input  logic              cs_fall_i,
    input  logic              cs_rise_i,
    input  logic              rd_fall_i,
    input  logic              rd_rise_i,
    input  logic              wr_fall_i,
    input  logic              wr_rise_i,
    input  logic              acq_busy_i,
    input  logic [NIB_W-1:0]  hi_i,
    input  logic [NIB_W-1:0]  lo_i,
    input  logic              done_i,
    output logic              complete_o,
    output logic [DATA_W-1:0] data_o,
    output logic              data_oe_o,
    output logic              int_n_o,
    output logic              rdy_pull_o,
    output logic              start_o,
    output logic              lower_o,
    output logic              finish_o,
    output logic              viol_o
);

    ctl_regs_t q;
    ctl_regs_t d;
    logic      complete;
    logic      selected;

    always_comb begin
        d        = q;
        d.start  = 1'b0;
        d.lower  = 1'b0;
        d.finish = 1'b0;
        d.viol   = 1'b0;
        complete = 1'b0;
        selected = ~cs_n_i;

        if (cs_rise_i || rd_rise_i) begin
            d.int_n = 1'b1;
        end
        if (!mode_i && cs_fall_i) begin
            d.rdy_pull = 1'b1;
        end
        if (cs_rise_i) begin
            d.rdy_pull = 1'b0;
        end

        unique case (q.st)
            ST_IDLE: begin
                if (!mode_i) begin
                    if (rd_fall_i && selected) begin
                        d.start = 1'b1;
                        d.valid = 1'b0;
                        d.int_n = 1'b1;
                        d.st    = ST_RD_BUSY;
                    end
                end else if (wr_fall_i && selected) begin
                    if (acq_busy_i) begin
                        d.viol = 1'b1;
                    end else begin
                        d.start = 1'b1;
                        d.int_n = 1'b1;
                        d.st    = ST_WR_TRACK;
                    end
                end
            end
            ST_RD_BUSY: begin
                if (done_i) begin
                    complete   = 1'b1;
                    d.data     = {hi_i, lo_i};
                    d.valid    = 1'b1;
                    d.int_n    = 1'b0;
                    d.rdy_pull = 1'b0;
                    d.st       = ST_IDLE;
                end
            end
            ST_WR_TRACK: begin
                if (wr_rise_i) begin
                    d.data[DATA_W-1:NIB_W] = hi_i;
                    d.valid = 1'b0;
                    d.lower = 1'b1;
                    d.st    = ST_WR_LOWER;
                end
            end
            ST_WR_LOWER: begin
                if (done_i) begin
                    complete            = 1'b1;
                    d.data[NIB_W-1:0]   = lo_i;
                    d.valid             = 1'b1;
                    d.int_n             = 1'b0;
                    d.st                = ST_IDLE;
                end else if (rd_fall_i && selected) begin
                    d.finish = 1'b1;
                end
            end
            default: begin
                d.st = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= CTL_RESET;
        end else begin
            q <= d;
        end
    end

    assign complete_o = complete;
    assign data_o     = q.data;
    assign data_oe_o  = q.valid & ~cs_n_i & ~rd_n_i;
    assign int_n_o    = q.int_n;
    assign rdy_pull_o = q.rdy_pull;
    assign start_o    = q.start;
    assign lower_o    = q.lower;
    assign finish_o   = q.finish;
    assign viol_o     = q.viol;

endmodule

// File: rtl/adc_bus_if.sv
module adc_bus_if
    import adc_bus_pkg::*;
#(
    parameter int unsigned ACQ_CYCLES = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode_i,
    input  logic              cs_n_i,
    input  logic              rd_n_i,
    input  logic              wr_n_i,
    output logic              int_n_o,
    output logic              rdy_pull_o,
    output logic [DATA_W-1:0] data_o,
    output logic              data_oe_o,
    output logic              conv_start_o,
    output logic              conv_lower_o,
    output logic              conv_finish_o,
    input  logic [NIB_W-1:0]  conv_hi_i,
    input  logic [NIB_W-1:0]  conv_lo_i,
    input  logic              conv_done_i,
    output logic              wr_viol_o
);

    logic [PIN_CNT-1:0] pins;
    logic [PIN_CNT-1:0] fall;
    logic [PIN_CNT-1:0] rise;
    logic               acq_busy;
    logic               complete;

    always_comb begin
        pins         = '1;
        pins[PIN_CS] = cs_n_i;
        pins[PIN_RD] = rd_n_i;
        pins[PIN_WR] = wr_n_i;
    end

    adc_bus_edges #(
        .N (PIN_CNT)
    ) u_edges (
        .clk    (clk),
        .rst_n  (rst_n),
        .pins_i (pins),
        .fall_o (fall),
        .rise_o (rise)
    );

    adc_bus_acq_timer #(
        .ACQ_CYCLES (ACQ_CYCLES)
    ) u_acq (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (complete),
        .busy_o (acq_busy)
    );

    adc_bus_ctrl u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .mode_i     (mode_i),
        .cs_n_i     (cs_n_i),
        .rd_n_i     (rd_n_i),
        .cs_fall_i  (fall[PIN_CS]),
        .cs_rise_i  (rise[PIN_CS]),
        .rd_fall_i  (fall[PIN_RD]),
        .rd_rise_i  (rise[PIN_RD]),
        .wr_fall_i  (fall[PIN_WR]),
        .wr_rise_i  (rise[PIN_WR]),
        .acq_busy_i (acq_busy),
        .hi_i       (conv_hi_i),
        .lo_i       (conv_lo_i),
        .done_i     (conv_done_i),
        .complete_o (complete),
        .data_o     (data_o),
        .data_oe_o  (data_oe_o),
        .int_n_o    (int_n_o),
        .rdy_pull_o (rdy_pull_o),
        .start_o    (conv_start_o),
        .lower_o    (conv_lower_o),
        .finish_o   (conv_finish_o),
        .viol_o     (wr_viol_o)
    );

endmodule

// File: rtl/adc_bus_if_chk.sv
module adc_bus_if_chk
    import adc_bus_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              mode_i,
    input logic              cs_n_i,
    input logic              rd_n_i,
    input logic              conv_done_i,
    input logic              int_n_o,
    input logic              rdy_pull_o,
    input logic [DATA_W-1:0] data_o,
    input logic              data_oe_o,
    input logic              conv_start_o,
    input logic              conv_lower_o,
    input logic              conv_finish_o,
    input logic              wr_viol_o
);

    AST_START_NEEDS_CS: assert property (@(posedge clk) disable iff (!rst_n)
        conv_start_o |-> $past(!cs_n_i)); // R2

    AST_SINGLE_REQUEST: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({conv_start_o, conv_lower_o, conv_finish_o, wr_viol_o})); // R6

    AST_INT_FALL_ON_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(int_n_o) |-> $past(conv_done_i)); // R5

    AST_INT_RISE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(int_n_o) |-> ($past(cs_n_i) || $past(rd_n_i) || conv_start_o)); // R5

    AST_RDY_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rdy_pull_o) |-> ($past(conv_done_i) || $past(cs_n_i))); // R4

    AST_VIOL_WRITE_MODE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_viol_o |-> $past(mode_i && !cs_n_i)); // R10

    AST_BUS_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (data_oe_o && $past(data_oe_o)) |-> $stable(data_o)); // R9

    AST_BUS_NEEDS_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
        data_oe_o |-> (!cs_n_i && !rd_n_i)); // R9

endmodule

bind adc_bus_if adc_bus_if_chk u_chk (.*);

// File: tb/adc_bus_if_tb_top.sv
module adc_bus_if_tb_top;

    localparam int ACQ = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       mode_i = 1'b0;
    logic       cs_n_i = 1'b1;
    logic       rd_n_i = 1'b1;
    logic       wr_n_i = 1'b1;
    logic       int_n_o;
    logic       rdy_pull_o;
    logic [7:0] data_o;
    logic       data_oe_o;
    logic       conv_start_o;
    logic       conv_lower_o;
    logic       conv_finish_o;
    logic [3:0] conv_hi_i = 4'h0;
    logic [3:0] conv_lo_i = 4'h0;
    logic       conv_done_i = 1'b0;
    logic       wr_viol_o;

    int  n_checks = 0;
    int  n_errors = 0;
    bit  finished = 1'b0;

    always #10 clk = ~clk;

    adc_bus_if #(.ACQ_CYCLES(ACQ)) dut_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .mode_i        (mode_i),
        .cs_n_i        (cs_n_i),
        .rd_n_i        (rd_n_i),
        .wr_n_i        (wr_n_i),
        .int_n_o       (int_n_o),
        .rdy_pull_o    (rdy_pull_o),
        .data_o        (data_o),
        .data_oe_o     (data_oe_o),
        .conv_start_o  (conv_start_o),
        .conv_lower_o  (conv_lower_o),
        .conv_finish_o (conv_finish_o),
        .conv_hi_i     (conv_hi_i),
        .conv_lo_i     (conv_lo_i),
        .conv_done_i   (conv_done_i),
        .wr_viol_o     (wr_viol_o)
    );

    function automatic logic [7:0] exp_word(input logic [3:0] hi, input logic [3:0] lo);
        return {hi, lo};
    endfunction

    function automatic logic exp_refused(input int k);
        return (k <= ACQ);
    endfunction

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(input string req, input string what,
                       input logic [7:0] act, input logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic idle_gap();
        cs_n_i = 1'b1;
        rd_n_i = 1'b1;
        wr_n_i = 1'b1;
        repeat (ACQ + 2) step();
    endtask

    task automatic rd_conv(input logic [3:0] hi, input logic [3:0] lo, input int lat);
        mode_i = 1'b0;
        cs_n_i = 1'b0;
        step();
        chk("R4", "rdy after cs fall", {7'd0, rdy_pull_o}, 8'd1);
        conv_hi_i = hi;
        conv_lo_i = lo;
        rd_n_i = 1'b0;
        step();
        chk("R3", "start pulse", {7'd0, conv_start_o}, 8'd1);
        chk("R9", "bus off during conversion", {7'd0, data_oe_o}, 8'd0);
        repeat (lat) step();
        chk("R5", "int high before done", {7'd0, int_n_o}, 8'd1);
        conv_done_i = 1'b1;
        step();
        conv_done_i = 1'b0;
        chk("R5", "int low after done", {7'd0, int_n_o}, 8'd0);
        chk("R4", "rdy released", {7'd0, rdy_pull_o}, 8'd0);
        chk("R9", "bus on", {7'd0, data_oe_o}, 8'd1);
        chk("R3", "read result", data_o, exp_word(hi, lo));
        rd_n_i = 1'b1;
        step();
        chk("R5", "int high after rd rise", {7'd0, int_n_o}, 8'd1);
        chk("R9", "bus off rd high", {7'd0, data_oe_o}, 8'd0);
        cs_n_i = 1'b1;
        step();
    endtask

    task automatic wr_conv(input logic [3:0] hi, input logic [3:0] lo, input int lat, input bit early);
        idle_gap();
        mode_i = 1'b1;
        cs_n_i = 1'b0;
        wr_n_i = 1'b0;
        conv_hi_i = hi;
        step();
        chk("R6", "start on wr fall", {7'd0, conv_start_o}, 8'd1);
        wr_n_i = 1'b1;
        step();
        chk("R6", "lower on wr rise", {7'd0, conv_lower_o}, 8'd1);
        conv_hi_i = ~hi;
        repeat (lat) step();
        if (early) begin
            rd_n_i = 1'b0;
            step();
            chk("R7", "finish pulse", {7'd0, conv_finish_o}, 8'd1);
            chk("R7", "int held high", {7'd0, int_n_o}, 8'd1);
            chk("R9", "bus off before done", {7'd0, data_oe_o}, 8'd0);
        end
        conv_lo_i = lo;
        conv_done_i = 1'b1;
        step();
        conv_done_i = 1'b0;
        chk("R5", "int low after done", {7'd0, int_n_o}, 8'd0);
        if (!early) begin
            rd_n_i = 1'b0;
            step();
        end
        chk("R9", "bus on", {7'd0, data_oe_o}, 8'd1);
        chk("R6", "write result", data_o, exp_word(hi, lo));
        rd_n_i = 1'b1;
        cs_n_i = 1'b1;
        step();
        chk("R5", "int high after cs rise", {7'd0, int_n_o}, 8'd1);
    endtask

    task automatic acq_case(input int k);
        idle_gap();
        mode_i = 1'b1;
        cs_n_i = 1'b0;
        wr_n_i = 1'b0;
        step();
        wr_n_i = 1'b1;
        step();
        conv_done_i = 1'b1;
        step();
        conv_done_i = 1'b0;
        repeat (k - 1) step();
        wr_n_i = 1'b0;
        step();
        chk("R10", $sformatf("viol at edge %0d", k), {7'd0, wr_viol_o}, {7'd0, exp_refused(k)});
        chk("R10", $sformatf("start at edge %0d", k), {7'd0, conv_start_o}, {7'd0, !exp_refused(k)});
        wr_n_i = 1'b1;
        step();
        if (!exp_refused(k)) begin
            conv_done_i = 1'b1;
            step();
            conv_done_i = 1'b0;
        end
        cs_n_i = 1'b1;
        step();
    endtask

    initial begin
        int seed;
        seed = 1234;
        void'($urandom(seed));
        repeat (3) step();
        chk("R5", "reset int", {7'd0, int_n_o}, 8'd1);
        chk("R4", "reset rdy", {7'd0, rdy_pull_o}, 8'd0);
        chk("R9", "reset bus", {7'd0, data_oe_o}, 8'd0);
        rst_n = 1'b1;
        step();
        chk("R6", "no request after reset",
            {4'd0, conv_start_o, conv_lower_o, conv_finish_o, wr_viol_o}, 8'd0);

        rd_conv(4'hA, 4'h5, 3);
        rd_conv(4'h0, 4'h0, 0);
        rd_conv(4'hF, 4'hF, 5);

        // R2: read fall with chip select high
        mode_i = 1'b0;
        rd_n_i = 1'b0;
        step();
        chk("R2", "no start cs high", {7'd0, conv_start_o}, 8'd0);
        rd_n_i = 1'b1;
        step();
        // R2: write fall with chip select high in write-read mode
        idle_gap();
        mode_i = 1'b1;
        wr_n_i = 1'b0;
        step();
        chk("R2", "no start wr cs high", {7'd0, conv_start_o}, 8'd0);
        chk("R2", "no viol cs high", {7'd0, wr_viol_o}, 8'd0);
        wr_n_i = 1'b1;
        step();

        // R1: write fall ignored in read mode
        mode_i = 1'b0;
        cs_n_i = 1'b0;
        step();
        wr_n_i = 1'b0;
        step();
        chk("R1", "wr ignored in read mode", {7'd0, conv_start_o}, 8'd0);
        wr_n_i = 1'b1;
        cs_n_i = 1'b1;
        step();
        chk("R4", "rdy released on cs rise", {7'd0, rdy_pull_o}, 8'd0);
        // R1: read fall ignored while idle in write-read mode
        idle_gap();
        mode_i = 1'b1;
        cs_n_i = 1'b0;
        step();
        chk("R4", "no rdy in write-read mode", {7'd0, rdy_pull_o}, 8'd0);
        rd_n_i = 1'b0;
        step();
        chk("R1", "rd ignored in write-read mode", {7'd0, conv_start_o}, 8'd0);
        rd_n_i = 1'b1;
        cs_n_i = 1'b1;
        step();

        wr_conv(4'h3, 4'hC, 2, 1'b0);
        wr_conv(4'h9, 4'h6, 1, 1'b1);

        acq_case(ACQ);
        acq_case(ACQ + 1);
        acq_case(1);

        // R8: stand-alone operation
        idle_gap();
        mode_i = 1'b1;
        cs_n_i = 1'b0;
        rd_n_i = 1'b0;
        step();
        conv_hi_i = 4'h7;
        wr_n_i = 1'b0;
        step();
        wr_n_i = 1'b1;
        step();
        conv_lo_i = 4'h2;
        conv_done_i = 1'b1;
        step();
        conv_done_i = 1'b0;
        chk("R8", "first result on bus", {7'd0, data_oe_o}, 8'd1);
        chk("R8", "first result value", data_o, exp_word(4'h7, 4'h2));
        repeat (ACQ + 1) step();
        conv_hi_i = 4'hE;
        wr_n_i = 1'b0;
        step();
        chk("R8", "start in stand-alone", {7'd0, conv_start_o}, 8'd1);
        chk("R5", "int high on new start", {7'd0, int_n_o}, 8'd1);
        chk("R8", "old result held on wr fall", data_o, exp_word(4'h7, 4'h2));
        chk("R8", "bus still on at wr fall", {7'd0, data_oe_o}, 8'd1);
        wr_n_i = 1'b1;
        step();
        chk("R8", "bus off after wr rise", {7'd0, data_oe_o}, 8'd0);
        conv_lo_i = 4'h1;
        conv_done_i = 1'b1;
        step();
        conv_done_i = 1'b0;
        chk("R8", "second result value", data_o, exp_word(4'hE, 4'h1));
        chk("R8", "second result on bus", {7'd0, data_oe_o}, 8'd1);
        rd_n_i = 1'b1;
        cs_n_i = 1'b1;
        step();

        // Random mix of transactions (R3, R6, R7)
        for (int i = 0; i < 40; i++) begin
            logic [3:0] h;
            logic [3:0] l;
            int         kind;
            int         lat;
            h    = 4'($urandom());
            l    = 4'($urandom());
            kind = int'($urandom() % 3);
            lat  = int'($urandom() % 4);
            if (kind == 0) begin
                rd_conv(h, l, lat);
            end else begin
                wr_conv(h, l, lat, kind == 2);
            end
        end

        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog run did not finish actual=hung expected=done");
            $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
            $finish;
        end
    end

endmodule